// File: doc/BRIEF.md
# DRAM Strobe Cycle-Type Detector

This block watches the two active-low address strobes of a dynamic memory, the row strobe and the column strobe, and reports which kind of cycle the memory is running. When the row strobe falls before the column strobe, the memory is doing an ordinary read or write access. When the column strobe falls first and the row strobe follows, the memory is being refreshed. The classification depends only on the order in which the strobes went low, so the block carries history in a small state machine.

Both strobes may come from a clock domain unrelated to the block's clock. Each strobe passes through a synchronizer chain of `SYNC_STAGES` flops. A state register follows, and two registered flags are the outputs. A flag changes exactly `SYNC_STAGES + 1` rising clock edges after the strobe level at the pin changes, provided the strobe holds its new level across those edges. The block only observes strobes. It drives nothing toward the memory.

The state machine has six named states. `ST_IDLE` means both strobes are high. `ST_ROW_FIRST` means only the row strobe is low. `ST_COL_FIRST` means only the column strobe is low. `ST_NORMAL` means both strobes are low and the row strobe fell first. `ST_REFRESH` means both strobes are low and the column strobe fell first. `ST_BOTH_FELL` means both strobes fell in the same sample while the machine was idle.

The transitions are:
- Both strobes high leads to `ST_IDLE` from every state.
- Only the row strobe low leads to `ST_ROW_FIRST` from every state except `ST_BOTH_FELL`.
- Only the column strobe low leads to `ST_COL_FIRST` from every state except `ST_BOTH_FELL`.
- Both strobes low leads to `ST_NORMAL` from `ST_ROW_FIRST`, to `ST_REFRESH` from `ST_COL_FIRST`, and to `ST_BOTH_FELL` from `ST_IDLE`. With both strobes low, `ST_NORMAL`, `ST_REFRESH` and `ST_BOTH_FELL` hold.
- `ST_BOTH_FELL` is left only when both strobes are high again.

Top module: `strobe_cycle_classifier`

## Requirements
- R1: While `rst` is high at a rising clock edge, the block enters `ST_IDLE` and both flags read 0 after that edge. This holds even when a cycle is in progress.
- R2: When the row strobe goes low and the column strobe goes low afterwards, `normal_cycle` reads 1. It stays 1 for as long as both strobes remain low, and `refresh_cycle` stays 0.
- R3: When the column strobe goes low and the row strobe goes low afterwards, `refresh_cycle` reads 1. It stays 1 for as long as both strobes remain low, and `normal_cycle` stays 0.
- R4: While exactly one strobe is low (`ST_ROW_FIRST` or `ST_COL_FIRST`), both flags read 0.
- R5: From a normal or refresh cycle, the column strobe rising leads to `ST_ROW_FIRST`, and the row strobe rising leads to `ST_COL_FIRST`. Lowering the released strobe again then reports according to the new order. Re-lowering the row strobe while the column strobe stays low gives `refresh_cycle`. Re-lowering the column strobe while the row strobe stays low gives `normal_cycle`.
- R6: Both strobes high returns the block to `ST_IDLE` with both flags 0 from any state. This includes both strobes rising in the same sample.
- R7: When both synchronized strobes fall in the same sample from idle, both flags stay 0 whatever the strobes then do, until both strobes are high again.
- R8: `normal_cycle` and `refresh_cycle` are never 1 in the same cycle.
- R9: A flag changes on the (`SYNC_STAGES` + 1)th rising clock edge after the strobe pin changes (3 edges with the default of 2), and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| row_stb_n | input | 1 | Row address strobe, active low, asynchronous to clk |
| col_stb_n | input | 1 | Column address strobe, active low, asynchronous to clk |
| normal_cycle | output | 1 | 1 while a normal access cycle is observed |
| refresh_cycle | output | 1 | 1 while a refresh cycle is observed |

## Verification
Two situations are hard to reach from the ports. The first is re-entering a cycle through a partial release, where one strobe rises and falls while the other is held low. The second is the state entered when both strobes fall within one sample. Directed sequences build each of these from a known state and check the flags at the exact edge where they should change. A long random walk follows, mixing single-strobe toggles, simultaneous toggles and idle stretches of varied length. On every clock, the flags are compared against a behavioural model that delays the pin levels through a queue.

// File: rtl/strobe_cls_pkg.sv
package strobe_cls_pkg;

    // Behavioural states of the strobe-order classifier
    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_ROW_FIRST = 3'd1,
        ST_NORMAL    = 3'd2,
        ST_COL_FIRST = 3'd3,
        ST_REFRESH   = 3'd4,
        ST_BOTH_FELL = 3'd5
    } cls_state_e;

endpackage

// File: rtl/strobe_sync.sv
// Multi-stage synchronizer for a bundle of asynchronous levels.
module strobe_sync #(
    parameter int          STAGES    = 2,
    parameter int          WIDTH     = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_d,
    output logic [WIDTH-1:0] sync_q
);

    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) begin
                    stage_q[g] <= RESET_VAL;
                end else begin
                    stage_q[g] <= async_d;
                end
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) begin
                    stage_q[g] <= RESET_VAL;
                end else begin
                    stage_q[g] <= stage_q[g-1];
                end
            end
        end
    end

    assign sync_q = stage_q[STAGES-1];

endmodule

// File: rtl/strobe_order_fsm.sv
// Tracks which strobe fell first. Levels are 1 = high (inactive).
module strobe_order_fsm
    import strobe_cls_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       row_lvl,
    input  logic       col_lvl,
    output cls_state_e state_q,
    output cls_state_e state_nx
);

    logic [1:0] lvl;
    assign lvl = {row_lvl, col_lvl};

    // Next-state process
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE: begin
                unique case (lvl)
                    2'b11: state_nx = ST_IDLE;
                    2'b01: state_nx = ST_ROW_FIRST;
                    2'b10: state_nx = ST_COL_FIRST;
                    2'b00: state_nx = ST_BOTH_FELL;
                    default: state_nx = ST_IDLE;
                endcase
            end
            ST_ROW_FIRST: begin
                unique case (lvl)
                    2'b11: state_nx = ST_IDLE;
                    2'b01: state_nx = ST_ROW_FIRST;
                    2'b10: state_nx = ST_COL_FIRST;
                    2'b00: state_nx = ST_NORMAL;
                    default: state_nx = ST_IDLE;
                endcase
            end
            ST_COL_FIRST: begin
                unique case (lvl)
                    2'b11: state_nx = ST_IDLE;
                    2'b01: state_nx = ST_ROW_FIRST;
                    2'b10: state_nx = ST_COL_FIRST;
                    2'b00: state_nx = ST_REFRESH;
                    default: state_nx = ST_IDLE;
                endcase
            end
            ST_NORMAL, ST_REFRESH: begin
                unique case (lvl)
                    2'b11: state_nx = ST_IDLE;
                    2'b01: state_nx = ST_ROW_FIRST;
                    2'b10: state_nx = ST_COL_FIRST;
                    2'b00: state_nx = state_q;
                    default: state_nx = ST_IDLE;
                endcase
            end
            ST_BOTH_FELL: begin
                state_nx = (lvl == 2'b11) ? ST_IDLE : ST_BOTH_FELL;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register process
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_nx;
        end
    end

    // R6
    release_to_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (row_lvl && col_lvl) |=> (state_q == ST_IDLE));

    // R4
    single_low_state_chk: assert property (@(posedge clk) disable iff (rst)
        ((row_lvl != col_lvl) && (state_q != ST_BOTH_FELL))
        |=> ((state_q == ST_ROW_FIRST) || (state_q == ST_COL_FIRST)));

    // R7
    both_fell_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ((state_q == ST_BOTH_FELL) && !(row_lvl && col_lvl))
        |=> (state_q == ST_BOTH_FELL));

endmodule

// File: rtl/cycle_flag_reg.sv
// Registered cycle-type flags decoded from the upcoming state.
module cycle_flag_reg
    import strobe_cls_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  cls_state_e state_nx,
    output logic       normal_q,
    output logic       refresh_q
);

    // Output process
    always_ff @(posedge clk) begin
        if (rst) begin
            normal_q  <= 1'b0;
            refresh_q <= 1'b0;
        end else begin
            normal_q  <= (state_nx == ST_NORMAL);
            refresh_q <= (state_nx == ST_REFRESH);
        end
    end

endmodule

// File: rtl/strobe_cycle_classifier.sv
module strobe_cycle_classifier
    import strobe_cls_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic row_stb_n,
    input  logic col_stb_n,
    output logic normal_cycle,
    output logic refresh_cycle
);

    localparam int LVL_W = 2;

    logic [LVL_W-1:0] lvl_sync;
    logic             row_s;
    logic             col_s;
    cls_state_e       state_q;
    cls_state_e       state_nx;

    strobe_sync #(
        .STAGES    (SYNC_STAGES),
        .WIDTH     (LVL_W),
        .RESET_VAL ({LVL_W{1'b1}})
    ) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_d ({row_stb_n, col_stb_n}),
        .sync_q  (lvl_sync)
    );

    assign row_s = lvl_sync[1];
    assign col_s = lvl_sync[0];

    strobe_order_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .row_lvl  (row_s),
        .col_lvl  (col_s),
        .state_q  (state_q),
        .state_nx (state_nx)
    );

    cycle_flag_reg u_flags (
        .clk       (clk),
        .rst       (rst),
        .state_nx  (state_nx),
        .normal_q  (normal_cycle),
        .refresh_q (refresh_cycle)
    );

    // R8
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(normal_cycle && refresh_cycle));

    // R2
    flag_needs_both_low_chk: assert property (@(posedge clk) disable iff (rst)
        (normal_cycle || refresh_cycle) |-> $past(!row_s && !col_s));

    // R5
    normal_entry_order_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(normal_cycle) |-> ($past(state_q) == ST_ROW_FIRST));

    // R3
    refresh_entry_order_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(refresh_cycle) |-> ($past(state_q) == ST_COL_FIRST));

endmodule

// File: tb/tb_strobe_cycle_classifier.sv
`timescale 1ns/1ps
module tb_strobe_cycle_classifier;

    localparam int SYNC_STAGES = 2;
    localparam time TCK = 8ns;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic row_n = 1'b1;
    logic col_n = 1'b1;
    logic normal_cycle;
    logic refresh_cycle;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(TCK/2) clk = ~clk;

    strobe_cycle_classifier #(.SYNC_STAGES(SYNC_STAGES)) dut (
        .clk           (clk),
        .rst           (rst),
        .row_stb_n     (row_n),
        .col_stb_n     (col_n),
        .normal_cycle  (normal_cycle),
        .refresh_cycle (refresh_cycle)
    );

    // Reference model: 0 idle, 1 row first, 2 normal, 3 col first, 4 refresh, 5 both fell
    int         mst = 0;
    logic [1:0] pq[$];
    bit         exp_n = 0;
    bit         exp_r = 0;

    function automatic int model_step(int s, logic [1:0] v);
        if (v == 2'b11) return 0;
        if (s == 5) return 5;
        if (v == 2'b01) return 1;
        if (v == 2'b10) return 3;
        if (s == 0) return 5;
        if (s == 1 || s == 2) return 2;
        return 4;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            mst = 0;
            pq.delete();
            for (int i = 0; i < SYNC_STAGES; i++) pq.push_back(2'b11);
        end else begin
            pq.push_back({row_n, col_n});
            mst = model_step(mst, pq.pop_front());
        end
        exp_n = (mst == 2);
        exp_r = (mst == 4);
    end

    task automatic chk(input logic got, input logic exp, input string tag);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b at %0t", tag, got, exp, $time);
        end
    endtask

    function automatic string tag_of(int s);
        case (s)
            2: return "R2";
            4: return "R3";
            5: return "R7";
            1, 3: return "R4";
            default: return "R6";
        endcase
    endfunction

    // Per-cycle comparison against the model
    bit track = 0;
    always @(negedge clk) begin
        if (track && !rst) begin
            chk(normal_cycle, exp_n, {tag_of(mst), " normal vs model"});
            chk(refresh_cycle, exp_r, {tag_of(mst), " refresh vs model"});
            chk(normal_cycle && refresh_cycle, 1'b0, "R8 exclusive");
        end
    end

    task automatic drive(input logic r, input logic c);
        @(posedge clk);
        #1;
        row_n = r;
        col_n = c;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(TCK * 200000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        settle(1);
        chk(normal_cycle, 1'b0, "R1 reset normal");
        chk(refresh_cycle, 1'b0, "R1 reset refresh");
        @(posedge clk);
        #1;
        rst = 1'b0;
        track = 1;
        settle(4);

        // R4: row alone low
        drive(1'b0, 1'b1);
        settle(6);
        chk(normal_cycle, 1'b0, "R4 row only");
        // R9: column falls, flag appears on third edge
        drive(1'b0, 1'b0);
        settle(3);
        chk(normal_cycle, 1'b0, "R9 before latency");
        settle(1);
        chk(normal_cycle, 1'b1, "R9 at latency");
        settle(10);
        chk(normal_cycle, 1'b1, "R2 held");
        chk(refresh_cycle, 1'b0, "R2 no refresh");
        // R5: column releases and re-falls -> normal again
        drive(1'b0, 1'b1);
        settle(5);
        chk(normal_cycle, 1'b0, "R5 col released");
        drive(1'b0, 1'b0);
        settle(5);
        chk(normal_cycle, 1'b1, "R5 col re-fall normal");
        // R5: row releases and re-falls -> refresh
        drive(1'b1, 1'b0);
        settle(5);
        chk(normal_cycle, 1'b0, "R5 row released");
        chk(refresh_cycle, 1'b0, "R4 col only");
        drive(1'b0, 1'b0);
        settle(5);
        chk(refresh_cycle, 1'b1, "R5 row re-fall refresh");
        chk(normal_cycle, 1'b0, "R3 no normal");
        // R6: both rise together
        drive(1'b1, 1'b1);
        settle(5);
        chk(refresh_cycle, 1'b0, "R6 double release");
        // R7: both fall together
        drive(1'b0, 1'b0);
        settle(6);
        chk(normal_cycle, 1'b0, "R7 both fell normal");
        chk(refresh_cycle, 1'b0, "R7 both fell refresh");
        drive(1'b0, 1'b1);
        settle(5);
        drive(1'b0, 1'b0);
        settle(5);
        chk(normal_cycle, 1'b0, "R7 still blocked");
        drive(1'b1, 1'b1);
        settle(5);
        // R3: column first then row
        drive(1'b1, 1'b0);
        settle(5);
        drive(1'b0, 1'b0);
        settle(5);
        chk(refresh_cycle, 1'b1, "R3 refresh");
        // R1: reset during a cycle
        @(posedge clk);
        #1;
        rst = 1'b1;
        settle(2);
        chk(normal_cycle, 1'b0, "R1 mid reset normal");
        chk(refresh_cycle, 1'b0, "R1 mid reset refresh");
        drive(1'b1, 1'b1);
        @(posedge clk);
        #1;
        rst = 1'b0;
        settle(4);

        // Random walk compared each cycle
        for (int step = 0; step < 3000; step++) begin
            int choice;
            choice = $urandom % 8;
            @(posedge clk);
            #1;
            if (choice < 3) row_n = ~row_n;
            else if (choice < 6) col_n = ~col_n;
            else if (choice == 6) begin
                row_n = ~row_n;
                col_n = ~col_n;
            end
            settle(($urandom % 6) + 1);
        end

        settle(4);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule